// File: doc/BRIEF.md
# Serial-Controlled Converter Power Sequencer

This block is the digital controller that sits beside a successive-approximation converter with a serial control port. Control arrives one bit at a time, with a strobe marking each bit. The first 1 the controller sees opens an 8-bit control word. The last two bits of that word choose how the conversion clock runs and what power state follows. The controller then runs through three phases in turn. It first waits out the reference power-up delay when the converter was asleep. It then performs one conversion, modelled as a fixed-latency busy period. Finally it either stays powered or drops into a full or fast software power-down.

An active-low hardware shutdown pin overrides every software choice on the spot. A static compensation-select input, together with the depth of the previous sleep, decides how long the power-up wait lasts. Both wait lengths are cycle counts supplied on input ports. The enable outputs drive the bandgap, the reference buffer and the converter core.

The state machine has six states:
- FULL_PD: everything off.
- FAST_PD: bandgap only.
- IDLE: powered and waiting.
- WAKE: power-up wait.
- CONV: conversion running.
- HWSD: hardware shutdown.

Its transitions are:
- FULL_PD, FAST_PD or IDLE on a complete control word: to WAKE, except IDLE, which goes straight to CONV.
- WAKE on timer expiry: to CONV.
- CONV on timer expiry: to IDLE, FAST_PD or FULL_PD, as the word's mode bits say.
- Any state while shdn_n is low: to HWSD.
- HWSD on shdn_n high: to FULL_PD.

Top module: `adc_pwr_seq`

## Requirements
- R1: A control word starts at the first bit_in=1 sampled with bit_vld=1. That start bit is the word's bit 7, and the next seven strobed bits follow MSB first. Zeros before the start bit are ignored, and so are cycles with bit_vld=0. The mode field is the last two bits sent: bit 1, then bit 0.
- R2: Mode 2'b00 ends the conversion in full power-down, 2'b01 in fast power-down, 2'b10 stays powered with the internal clock, and 2'b11 stays powered with the external clock.
- R3: Each accepted word gives exactly one conversion. During it conv_en is high for CONV_INT_CYC cycles (internal clock) or CONV_EXT_CYC cycles (external clock). done pulses for one cycle right after the last conversion cycle.
- R4: Modes 2'b00 and 2'b01 convert with the last selected clock mode. clk_ext shows that mode (1 = external).
- R5: pu_wait is high for a number of cycles before the conversion, set by the state the word arrived in. From IDLE there is no wait. From fast power-down the wait is wake_short. From full power-down, reset or hardware shutdown it is wake_short when comp_int=1 and wake_long when comp_int=0.
- R6: In full power-down bg_en=0 and ref_en=0. In fast power-down bg_en=1 and ref_en=0. In IDLE, the wait and the conversion, both are 1. conv_en is high only during a conversion.
- R7: busy is high exactly during the wait and the conversion. A control word sent while busy is ignored: no further conversion and no mode change.
- R8: With shdn_n=0, bg_en, ref_en, conv_en, pu_wait and busy are 0 in the same cycle. A running conversion is dropped without done, and serial words are ignored. After shdn_n returns to 1 the block is in full power-down.
- R9: After reset the block is in full power-down with the internal clock mode, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Hardware shutdown, active low |
| comp_int | input | 1 | 1 = internal reference compensation |
| wake_short | input | CW | Short power-up wait in cycles |
| wake_long | input | CW | Long power-up wait in cycles |
| bit_vld | input | 1 | Serial bit strobe |
| bit_in | input | 1 | Serial control data |
| bg_en | output | 1 | Bandgap enable |
| ref_en | output | 1 | Reference-buffer enable |
| conv_en | output | 1 | Converter core enable (conversion running) |
| pu_wait | output | 1 | Power-up wait in progress |
| busy | output | 1 | Wait or conversion in progress |
| done | output | 1 | One-cycle conversion-complete strobe |
| clk_ext | output | 1 | Current clock mode, 1 = external |

## Verification
The bench walks an ordered chain of control words, so that every wait length is tested from the right prior state. A design that ignored the sleep depth would show a long wait after fast power-down. One that reset the clock mode on a power-down word would show the wrong conversion length for modes 00 and 01. A second word sent while the block is busy must leave both the clock mode and the idle state unchanged. A design that let it through would run a second conversion or flip clk_ext. Shutdown is pulled in mid-conversion: enables that lagged by a cycle, a done strobe from the aborted conversion, or a short wait on the next wake from a deep sleep would each be reported.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [2:0] {
        ST_FULL_PD = 3'd0,
        ST_FAST_PD = 3'd1,
        ST_IDLE    = 3'd2,
        ST_WAKE    = 3'd3,
        ST_CONV    = 3'd4,
        ST_HWSD    = 3'd5
    } seq_state_e;

    localparam logic [1:0] MODE_FULL   = 2'b00;
    localparam logic [1:0] MODE_FAST   = 2'b01;
    localparam logic [1:0] MODE_INTCLK = 2'b10;
    localparam logic [1:0] MODE_EXTCLK = 2'b11;

    localparam int CTRL_BITS = 8;
endpackage

// File: rtl/adcseq_rx.sv
module adcseq_rx #(
    parameter int NBITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic       word_vld,
    output logic [1:0] mode_q
);
    localparam int CNTW = $clog2(NBITS);

    logic [CNTW-1:0] cnt;
    logic            active;
    logic            prev_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            active   <= 1'b0;
            prev_bit <= 1'b0;
            word_vld <= 1'b0;
            mode_q   <= 2'b00;
        end else if (clr) begin
            cnt      <= '0;
            active   <= 1'b0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (bit_vld) begin
                prev_bit <= bit_in;
                if (!active) begin
                    if (bit_in) begin
                        active <= 1'b1;
                        cnt    <= CNTW'(1);
                    end
                end else if (cnt == CNTW'(NBITS - 1)) begin
                    mode_q   <= {prev_bit, bit_in};
                    word_vld <= 1'b1;
                    active   <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1
    rx_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(bit_vld));

    // R7
    rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !word_vld);
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] ld_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (ld_val == '0) ? TW'(1) : ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == TW'(1));

    // R3
    tmr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> !expired);
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int TW           = 16,
    parameter int CONV_INT_CYC = 8,
    parameter int CONV_EXT_CYC = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shdn_n,
    input  logic          comp_int,
    input  logic [TW-1:0] wake_short,
    input  logic [TW-1:0] wake_long,
    input  logic          word_vld,
    input  logic [1:0]    mode,
    input  logic          expired,
    output logic          load,
    output logic [TW-1:0] ld_val,
    output logic          rx_clr,
    output logic          bg_en,
    output logic          ref_en,
    output logic          conv_en,
    output logic          pu_wait,
    output logic          busy,
    output logic          done,
    output logic          clk_ext
);
    localparam logic [TW-1:0] CONV_INT_LEN = TW'(CONV_INT_CYC);
    localparam logic [TW-1:0] CONV_EXT_LEN = TW'(CONV_EXT_CYC);

    seq_state_e    state, nxt;
    logic [1:0]    pd_q;
    logic          ext_nxt;
    logic [TW-1:0] conv_len;
    logic          accepting;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FULL_PD;
        else        state <= nxt;
    end

    // latched word fields and completion strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q    <= MODE_FULL;
            clk_ext <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (state == ST_CONV) && expired && shdn_n;
            if (word_vld && accepting && shdn_n) begin
                pd_q    <= mode;
                clk_ext <= ext_nxt;
            end
        end
    end

    assign accepting = (state == ST_FULL_PD) || (state == ST_FAST_PD) ||
                       (state == ST_IDLE);
    assign rx_clr    = !accepting || !shdn_n;

    // next state and timer control
    always_comb begin
        nxt     = state;
        load    = 1'b0;
        ld_val  = '0;
        ext_nxt = clk_ext;
        if (word_vld && mode[1]) ext_nxt = mode[0];
        conv_len = ext_nxt ? CONV_EXT_LEN : CONV_INT_LEN;
        unique case (state)
            ST_FULL_PD, ST_FAST_PD: begin
                if (word_vld) begin
                    nxt    = ST_WAKE;
                    load   = 1'b1;
                    ld_val = (state == ST_FAST_PD || comp_int) ? wake_short
                                                               : wake_long;
                end
            end
            ST_IDLE: begin
                if (word_vld) begin
                    nxt    = ST_CONV;
                    load   = 1'b1;
                    ld_val = conv_len;
                end
            end
            ST_WAKE: begin
                if (expired) begin
                    nxt    = ST_CONV;
                    load   = 1'b1;
                    ld_val = conv_len;
                end
            end
            ST_CONV: begin
                if (expired) begin
                    if (pd_q[1])      nxt = ST_IDLE;
                    else if (pd_q[0]) nxt = ST_FAST_PD;
                    else              nxt = ST_FULL_PD;
                end
            end
            ST_HWSD: begin
                if (shdn_n) nxt = ST_FULL_PD;
            end
            default: nxt = ST_FULL_PD;
        endcase
        if (!shdn_n) begin
            nxt  = ST_HWSD;
            load = 1'b0;
        end
    end

    // outputs
    always_comb begin
        bg_en   = 1'b0;
        ref_en  = 1'b0;
        conv_en = 1'b0;
        pu_wait = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_FAST_PD: bg_en = 1'b1;
            ST_IDLE: begin
                bg_en  = 1'b1;
                ref_en = 1'b1;
            end
            ST_WAKE: begin
                bg_en   = 1'b1;
                ref_en  = 1'b1;
                pu_wait = 1'b1;
                busy    = 1'b1;
            end
            ST_CONV: begin
                bg_en   = 1'b1;
                ref_en  = 1'b1;
                conv_en = 1'b1;
                busy    = 1'b1;
            end
            default: ;
        endcase
        if (!shdn_n) begin
            bg_en   = 1'b0;
            ref_en  = 1'b0;
            conv_en = 1'b0;
            pu_wait = 1'b0;
            busy    = 1'b0;
        end
    end

    // R8
    hw_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (state == ST_HWSD));

    // R3
    done_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_CONV));

    // R5
    wake_to_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && expired && shdn_n) |=> (conv_en || !shdn_n));

    // R2
    conv_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && expired && shdn_n && !pd_q[1]) |=> !ref_en);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_en && pu_wait));
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adcseq_pkg::*;
#(
    parameter int CW           = 16,
    parameter int CONV_INT_CYC = 8,
    parameter int CONV_EXT_CYC = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shdn_n,
    input  logic          comp_int,
    input  logic [CW-1:0] wake_short,
    input  logic [CW-1:0] wake_long,
    input  logic          bit_vld,
    input  logic          bit_in,
    output logic          bg_en,
    output logic          ref_en,
    output logic          conv_en,
    output logic          pu_wait,
    output logic          busy,
    output logic          done,
    output logic          clk_ext
);
    localparam int TW = CW;

    logic          word_vld;
    logic [1:0]    mode;
    logic          rx_clr;
    logic          load;
    logic [TW-1:0] ld_val;
    logic          expired;

    adcseq_rx #(.NBITS(CTRL_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .word_vld (word_vld),
        .mode_q   (mode)
    );

    adcseq_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_val  (ld_val),
        .expired (expired)
    );

    adcseq_fsm #(
        .TW           (TW),
        .CONV_INT_CYC (CONV_INT_CYC),
        .CONV_EXT_CYC (CONV_EXT_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .comp_int   (comp_int),
        .wake_short (wake_short),
        .wake_long  (wake_long),
        .word_vld   (word_vld),
        .mode       (mode),
        .expired    (expired),
        .load       (load),
        .ld_val     (ld_val),
        .rx_clr     (rx_clr),
        .bg_en      (bg_en),
        .ref_en     (ref_en),
        .conv_en    (conv_en),
        .pu_wait    (pu_wait),
        .busy       (busy),
        .done       (done),
        .clk_ext    (clk_ext)
    );
endmodule

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;
    localparam int CW = 16;
    localparam int WS = 6;
    localparam int WL = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shdn_n = 1'b1;
    logic comp_int = 1'b1;
    logic [CW-1:0] wake_short = CW'(WS);
    logic [CW-1:0] wake_long = CW'(WL);
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic bg_en, ref_en, conv_en, pu_wait, busy, done, clk_ext;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_pwr_seq #(.CW(CW), .CONV_INT_CYC(8), .CONV_EXT_CYC(14)) uut (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .comp_int(comp_int),
        .wake_short(wake_short), .wake_long(wake_long),
        .bit_vld(bit_vld), .bit_in(bit_in),
        .bg_en(bg_en), .ref_en(ref_en), .conv_en(conv_en),
        .pu_wait(pu_wait), .busy(busy), .done(done), .clk_ext(clk_ext)
    );

    typedef struct packed {
        logic       comp;
        logic [1:0] mode;
        int         exp_wait;
        int         exp_conv;
        logic       exp_bg;
        logic       exp_ref;
        logic       exp_ext;
    } vec_t;

    // ordered chain: each row starts from the state the previous one left
    localparam vec_t VECS [7] = '{
        '{1'b1, 2'b10, WS, 8,  1'b1, 1'b1, 1'b0},  // full -> int clk, stay up
        '{1'b1, 2'b11, 0,  14, 1'b1, 1'b1, 1'b1},  // idle -> ext clk
        '{1'b1, 2'b01, 0,  14, 1'b1, 1'b0, 1'b1},  // fast pd, keeps ext clk
        '{1'b0, 2'b10, WS, 8,  1'b1, 1'b1, 1'b0},  // from fast: short wait
        '{1'b0, 2'b00, 0,  8,  1'b0, 1'b0, 1'b0},  // full pd, keeps int clk
        '{1'b0, 2'b10, WL, 8,  1'b1, 1'b1, 1'b0},  // from full, ext comp
        '{1'b1, 2'b00, 0,  8,  1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // leading zeros and a non-strobed 1 precede the word (R1)
    task automatic send_word(input logic [1:0] mode);
        logic [7:0] w;
        w = {1'b1, 5'b10110, mode};
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); bit_vld = 1'b1; bit_in = 1'b0;
            @(negedge clk); bit_vld = 1'b0;
        end
        @(negedge clk); bit_in = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); bit_vld = 1'b1; bit_in = w[i];
            @(negedge clk); bit_vld = 1'b0; bit_in = 1'b0;
        end
    endtask

    task automatic measure(output int w, output int c, output bit got, output int bad);
        w = 0; c = 0; got = 1'b0; bad = 0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (pu_wait) w++;
            if (conv_en) c++;
            if (busy != (pu_wait | conv_en)) bad++;
            if (done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w, c, bad, cnt;
        bit got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(bg_en == 0, "R9 bg_en", int'(bg_en), 0);
        chk(ref_en == 0, "R9 ref_en", int'(ref_en), 0);
        chk(conv_en == 0 && pu_wait == 0, "R9 conv/wait", int'(conv_en | pu_wait), 0);
        chk(busy == 0 && done == 0, "R9 busy/done", int'(busy | done), 0);
        chk(clk_ext == 0, "R9 clk_ext", int'(clk_ext), 0);

        // R1: strobed zeros never open a word
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); bit_vld = 1'b1; bit_in = 1'b0;
            @(negedge clk); bit_vld = 1'b0;
            if (busy) cnt++;
        end
        repeat (5) begin @(negedge clk); if (busy) cnt++; end
        chk(cnt == 0, "R1 zeros ignored", cnt, 0);

        // table walk: R2 R3 R4 R5 R6 R7
        foreach (VECS[i]) begin
            comp_int = VECS[i].comp;
            send_word(VECS[i].mode);
            measure(w, c, got, bad);
            chk(w == VECS[i].exp_wait, "R5 wait length", w, VECS[i].exp_wait);
            chk(c == VECS[i].exp_conv, "R3 conversion length", c, VECS[i].exp_conv);
            chk(got, "R3 done seen", int'(got), 1);
            chk(bad == 0, "R7 busy tracks wait/conv", bad, 0);
            chk(bg_en == VECS[i].exp_bg, "R6 bg_en after", int'(bg_en), int'(VECS[i].exp_bg));
            chk(ref_en == VECS[i].exp_ref, "R2 ref_en after", int'(ref_en), int'(VECS[i].exp_ref));
            chk(clk_ext == VECS[i].exp_ext, "R4 clk_ext", int'(clk_ext), int'(VECS[i].exp_ext));
            @(negedge clk);
            chk(done == 0, "R3 done one cycle", int'(done), 0);
        end

        // R7: second word during busy ignored (now in full pd, comp_int=1)
        wake_short = CW'(30);
        send_word(2'b10);
        send_word(2'b11);
        got = 1'b0;
        for (int t = 0; t < 200 && !got; t++) begin
            @(negedge clk);
            if (done) got = 1'b1;
        end
        chk(got, "R7 first conversion done", int'(got), 1);
        cnt = 0;
        repeat (30) begin @(negedge clk); if (busy) cnt++; end
        chk(cnt == 0, "R7 no second conversion", cnt, 0);
        chk(clk_ext == 0, "R7 mode unchanged", int'(clk_ext), 0);
        chk(ref_en == 1, "R7 still idle", int'(ref_en), 1);
        wake_short = CW'(WS);

        // R8: hardware shutdown mid-conversion
        send_word(2'b10);
        repeat (3) @(negedge clk);
        chk(conv_en == 1, "R8 converting before shutdown", int'(conv_en), 1);
        shdn_n = 1'b0;
        #1;
        chk({bg_en, ref_en, conv_en, pu_wait, busy} == 5'b0, "R8 same-cycle off",
            int'({bg_en, ref_en, conv_en, pu_wait, busy}), 0);
        send_word(2'b10);
        cnt = 0;
        repeat (20) begin @(negedge clk); if (done || busy || bg_en) cnt++; end
        chk(cnt == 0, "R8 no done, word ignored", cnt, 0);
        shdn_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bg_en == 0 && ref_en == 0 && busy == 0, "R8 full pd after release",
            int'({bg_en, ref_en, busy}), 0);
        comp_int = 1'b0;
        send_word(2'b10);
        measure(w, c, got, bad);
        chk(w == WL, "R8 R5 long wait after shutdown", w, WL);
        chk(c == 8, "R8 conversion after shutdown", c, 8);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule